// File: doc/BRIEF.md
# Byte-Wide Readout Silo

This block is a three-entry queue of 16-bit words that a 12-bit host drains one byte at a time. A completing function fills the queue in one cycle, from either of two sources. A status fetch copies one drive status word into every entry. A header fetch places the packed track and sector address in the head entry and zeros in the two entries behind it.

Each host read strobe returns one byte of the head entry, zero-extended to the 12-bit host width. A one-bit side pointer chooses the byte. The low byte comes out first and the high byte second. After the high byte the queue shifts one place toward the head. The tail keeps its value, so further reads repeat the last word. Whenever a new function is issued, the side pointer returns to the low byte. This lets a function leave the queue in a known state.

Top module: `byte_silo`

## Requirements
- R1: After an active-low reset, all three entries are zero, the side pointer selects the low byte and `rd_data_o` is zero.
- R2: A read with the side pointer on the low side drives bits 7:0 of the head entry onto `rd_data_o` bits 7:0 one cycle later, and bits 11:8 are zero.
- R3: A read with the side pointer on the high side drives bits 15:8 of the head entry onto `rd_data_o` bits 7:0. The queue then shifts: entry 1 moves to entry 0 and entry 2 moves to entry 1.
- R4: In a shift, the last entry keeps its old value, so reads past the loaded words repeat the last entry's bytes.
- R5: Every read that is not overridden by a load flips the side pointer.
- R6: `func_issue_i` clears the side pointer to the low side and leaves the entries unchanged.
- R7: `stat_load_i` writes `stat_word_i` into all three entries.
- R8: `hdr_load_i` writes `{hdr_track_i, hdr_sector_i}` (track shifted left by 6, with the sector in bits 5:0) into entry 0, and zero into entries 1 and 2.
- R9: A load in the same cycle as a read wins. The entries take the load, the side pointer does not flip, and `rd_data_o` holds its previous value.
- R10: If both loads are asserted in one cycle, the status load is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| func_issue_i | input | 1 | A new function is issued; clears the side pointer |
| stat_load_i | input | 1 | Fill all entries with the status word |
| stat_word_i | input | 16 | Drive status word |
| hdr_load_i | input | 1 | Fill the head entry with the header word |
| hdr_track_i | input | 10 | Track number for the header word |
| hdr_sector_i | input | 6 | Sector number for the header word |
| rd_i | input | 1 | Host read strobe, one byte per cycle held |
| rd_data_o | output | 12 | Byte returned by the last read, zero-extended |

## Verification
A status load with unequal low and high bytes, drained for eight reads, separates the byte order from the pointer toggle. It also shows that all three entries and the held tail carry the same word. A header load with nonzero track and sector shows the field packing and the shift of zeros into the head. A third pattern clears the pointer between two low-byte reads, which shows that the clear acts on the pointer alone and not on the entries. Two collision patterns check the precedence rules: a load arriving with a read while the pointer sits on the high side, and both loads in one cycle.

// File: rtl/silo_pkg.sv
package silo_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_STAT = 2'd1,
    LD_HDR  = 2'd2
  } ld_sel_e;
endpackage

// File: rtl/silo_load_ctl.sv
module silo_load_ctl
  import silo_pkg::*;
(
  input  logic    stat_load_i,
  input  logic    hdr_load_i,
  output ld_sel_e ld_sel_o
);
  // status fill outranks header fill
  always_comb begin
    if (stat_load_i)     ld_sel_o = LD_STAT;
    else if (hdr_load_i) ld_sel_o = LD_HDR;
    else                 ld_sel_o = LD_NONE;
  end
endmodule

// File: rtl/silo_fill.sv
module silo_fill
  import silo_pkg::*;
#(
  parameter int DEPTH   = 3,
  parameter int ENTRY_W = 16,
  parameter int SECT_W  = 6,
  localparam int TRK_W  = ENTRY_W - SECT_W
) (
  input  ld_sel_e                        ld_sel_i,
  input  logic [ENTRY_W-1:0]             stat_word_i,
  input  logic [TRK_W-1:0]               hdr_track_i,
  input  logic [SECT_W-1:0]              hdr_sector_i,
  output logic [DEPTH-1:0][ENTRY_W-1:0]  fill_o
);
  logic [ENTRY_W-1:0] hdr_word;
  assign hdr_word = {hdr_track_i, hdr_sector_i};

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    if (g == 0) begin : g_head
      assign fill_o[g] = (ld_sel_i == LD_STAT) ? stat_word_i : hdr_word;
    end else begin : g_rest
      assign fill_o[g] = (ld_sel_i == LD_STAT) ? stat_word_i : '0;
    end
  end
endmodule

// File: rtl/silo_side_ptr.sv
module silo_side_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic side_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     side_o <= 1'b0;
    else if (clr_i)  side_o <= 1'b0;
    else if (step_i) side_o <= ~side_o;
  end
endmodule

// File: rtl/silo_byte_pick.sv
module silo_byte_pick #(
  parameter int ENTRY_W = 16,
  parameter int BYTE_W  = 8,
  parameter int HOST_W  = 12
) (
  input  logic [ENTRY_W-1:0] head_i,
  input  logic               side_i,
  output logic [HOST_W-1:0]  byte_o
);
  logic [BYTE_W-1:0] sel;
  assign sel    = side_i ? head_i[2*BYTE_W-1:BYTE_W] : head_i[BYTE_W-1:0];
  assign byte_o = {{(HOST_W-BYTE_W){1'b0}}, sel};
endmodule

// File: rtl/byte_silo.sv
module byte_silo
  import silo_pkg::*;
#(
  parameter int DEPTH   = 3,
  parameter int ENTRY_W = 16,
  parameter int BYTE_W  = 8,
  parameter int HOST_W  = 12,
  parameter int SECT_W  = 6,
  localparam int TRK_W  = ENTRY_W - SECT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               func_issue_i,
  input  logic               stat_load_i,
  input  logic [ENTRY_W-1:0] stat_word_i,
  input  logic               hdr_load_i,
  input  logic [TRK_W-1:0]   hdr_track_i,
  input  logic [SECT_W-1:0]  hdr_sector_i,
  input  logic               rd_i,
  output logic [HOST_W-1:0]  rd_data_o
);
  ld_sel_e                       ld_sel;
  logic [DEPTH-1:0][ENTRY_W-1:0] fill;
  logic [DEPTH-1:0][ENTRY_W-1:0] ent_q;
  logic                          side_q;
  logic                          ld_any;
  logic                          rd_eff;
  logic                          shift;
  logic [HOST_W-1:0]             pick;

  silo_load_ctl u_ld_ctl (
    .stat_load_i (stat_load_i),
    .hdr_load_i  (hdr_load_i),
    .ld_sel_o    (ld_sel)
  );

  silo_fill #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .SECT_W(SECT_W)) u_fill (
    .ld_sel_i     (ld_sel),
    .stat_word_i  (stat_word_i),
    .hdr_track_i  (hdr_track_i),
    .hdr_sector_i (hdr_sector_i),
    .fill_o       (fill)
  );

  assign ld_any = (ld_sel != LD_NONE);
  assign rd_eff = rd_i & ~ld_any;
  assign shift  = rd_eff & side_q;

  silo_side_ptr u_side (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (func_issue_i),
    .step_i (rd_eff),
    .side_o (side_q)
  );

  silo_byte_pick #(.ENTRY_W(ENTRY_W), .BYTE_W(BYTE_W), .HOST_W(HOST_W)) u_pick (
    .head_i (ent_q[0]),
    .side_i (side_q),
    .byte_o (pick)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ENTRY_W-1:0] next_in;
    if (g == DEPTH-1) begin : g_tail
      assign next_in = ent_q[g];      // tail holds on shift
    end else begin : g_body
      assign next_in = ent_q[g+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q[g] <= '0;
      else if (ld_any) ent_q[g] <= fill[g];
      else if (shift)  ent_q[g] <= next_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_data_o <= '0;
    else if (rd_eff) rd_data_o <= pick;
  end
endmodule

// File: rtl/byte_silo_chk.sv
module byte_silo_chk #(
  parameter int DEPTH   = 3,
  parameter int ENTRY_W = 16,
  parameter int HOST_W  = 12,
  parameter int BYTE_W  = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          func_issue_i,
  input logic                          stat_load_i,
  input logic [ENTRY_W-1:0]            stat_word_i,
  input logic                          hdr_load_i,
  input logic                          rd_i,
  input logic                          side_i,
  input logic [DEPTH-1:0][ENTRY_W-1:0] ent_i,
  input logic [HOST_W-1:0]             rd_data_o
);
  logic quiet_rd;
  assign quiet_rd = rd_i & ~stat_load_i & ~hdr_load_i;

  assert_zero_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_rd |=> rd_data_o[HOST_W-1:BYTE_W] == '0);

  assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_rd && side_i) |=> ent_i[0] == $past(ent_i[1]));

  assert_tail_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_rd && side_i) |=> $stable(ent_i[DEPTH-1]));

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_rd && !func_issue_i) |=> side_i != $past(side_i));

  assert_issue_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_issue_i |=> !side_i);

  assert_stat_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_load_i |=> (ent_i[0] == $past(stat_word_i)) && (ent_i[DEPTH-1] == $past(stat_word_i)));

  assert_hdr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && !stat_load_i) |=> ent_i[1] == '0);

  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (stat_load_i || hdr_load_i)) |=> $stable(rd_data_o));
endmodule

bind byte_silo byte_silo_chk #(
  .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .HOST_W(HOST_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .func_issue_i (func_issue_i),
  .stat_load_i  (stat_load_i),
  .stat_word_i  (stat_word_i),
  .hdr_load_i   (hdr_load_i),
  .rd_i         (rd_i),
  .side_i       (side_q),
  .ent_i        (ent_q),
  .rd_data_o    (rd_data_o)
);

// File: tb/byte_silo_bench.sv
module byte_silo_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        func_issue_i = 1'b0;
  logic        stat_load_i = 1'b0;
  logic [15:0] stat_word_i = '0;
  logic        hdr_load_i = 1'b0;
  logic [9:0]  hdr_track_i = '0;
  logic [5:0]  hdr_sector_i = '0;
  logic        rd_i = 1'b0;
  logic [11:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  byte_silo u_byte_silo (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic rd_byte(output logic [11:0] v);
    @(negedge clk_i) rd_i = 1'b1;
    @(negedge clk_i) rd_i = 1'b0;
    v = rd_data_o;
  endtask

  task automatic issue();
    @(negedge clk_i) func_issue_i = 1'b1;
    @(negedge clk_i) func_issue_i = 1'b0;
  endtask

  task automatic load_stat(input logic [15:0] w);
    @(negedge clk_i) begin stat_load_i = 1'b1; stat_word_i = w; end
    @(negedge clk_i) stat_load_i = 1'b0;
  endtask

  task automatic load_hdr(input logic [9:0] t, input logic [5:0] s);
    @(negedge clk_i) begin hdr_load_i = 1'b1; hdr_track_i = t; hdr_sector_i = s; end
    @(negedge clk_i) hdr_load_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [11:0] v;
    check("R1 out", rd_data_o, 12'h000);
    rd_byte(v); check("R1 low", v, 12'h000);
    rd_byte(v); check("R1 high", v, 12'h000);
  endtask

  task automatic t_status();
    logic [11:0] v;
    issue();
    load_stat(16'hA5C3);
    for (int i = 0; i < 8; i++) begin
      rd_byte(v);
      check((i < 6) ? "R7 R2 R3 R5" : "R4 repeat", v, (i % 2 == 0) ? 12'h0C3 : 12'h0A5);
    end
  endtask

  task automatic t_header();
    logic [11:0] v;
    logic [11:0] exp [6] = '{12'h05D, 12'h0AD, 12'h000, 12'h000, 12'h000, 12'h000};
    issue();
    load_hdr(10'h2B5, 6'h1D);  // 0xAD5D
    for (int i = 0; i < 6; i++) begin
      rd_byte(v);
      check((i < 2) ? "R8 head" : "R8 R3 zeros", v, exp[i]);
    end
  endtask

  task automatic t_issue_clear();
    logic [11:0] v;
    issue();
    load_stat(16'h1234);
    rd_byte(v); check("R6 first low", v, 12'h034);
    issue();
    rd_byte(v); check("R6 low again", v, 12'h034);
    rd_byte(v); check("R6 high", v, 12'h012);
  endtask

  task automatic t_collide();
    logic [11:0] v;
    issue();
    load_stat(16'h1234);
    rd_byte(v); check("R9 pre", v, 12'h034);
    @(negedge clk_i) begin rd_i = 1'b1; stat_load_i = 1'b1; stat_word_i = 16'hBEEF; end
    @(negedge clk_i) begin rd_i = 1'b0; stat_load_i = 1'b0; end
    check("R9 held", rd_data_o, 12'h034);
    rd_byte(v); check("R9 side kept", v, 12'h0BE);
  endtask

  task automatic t_both_loads();
    logic [11:0] v;
    issue();
    @(negedge clk_i) begin
      stat_load_i = 1'b1; stat_word_i = 16'h00FF;
      hdr_load_i = 1'b1; hdr_track_i = 10'h001; hdr_sector_i = 6'h01;
    end
    @(negedge clk_i) begin stat_load_i = 1'b0; hdr_load_i = 1'b0; end
    for (int i = 0; i < 5; i++) begin
      rd_byte(v);
      check("R10 status wins", v, (i % 2 == 0) ? 12'h0FF : 12'h000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_status();
    t_header();
    t_issue_clear();
    t_collide();
    t_both_loads();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule